// File: doc/BRIEF.md
# Three-Product Coin Vending Controller

This controller sits between three coin sensors and three product motors of a drink vending machine. Each sensor sends a one-cycle pulse when it sees its coin: 25, 10 or 5 cents. The controller keeps one shared credit register for all coins. A two-bit item select input names the product the customer wants. When the credit, including any coins that arrive in the same cycle, covers that product's price, the matching motor output pulses for one cycle and the price is taken from the credit.

Prices are 125 cents for the X product, 30 for Y and 60 for Z. Credit is capped at 255 cents. A refund request clears the credit and reports, for one cycle, the amount given back. All outputs are registered, so every decision made at a clock edge is visible on the ports right after that edge. Coins and motors are single wires with no handshake. The refund output has a valid strobe but no ready input: it cannot be held back, so the receiver must take the amount in the cycle that `refund_valid` is high.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low, `credit`, all three motor outputs, `refund_valid` and `refund_amt` are zero.
- R2: A pulse on `coin_quarter`, `coin_dime` or `coin_nickel` adds 25, 10 or 5 cents. When several of these are high in the same cycle, all of them are counted.
- R3: `item_sel` encoding: 0 selects X (125 cents, `motor_x`), 1 selects Y (30 cents, `motor_y`), 2 selects Z (60 cents, `motor_z`), and 3 selects nothing.
- R4: The working sum is the credit plus the coins of the current cycle, capped as in R7. If this sum is at least the selected price, then after the clock edge the selected motor is high for that one cycle and `credit` equals the sum minus the price.
- R5: At most one motor output is high in any cycle, and only the motor of the selected item.
- R6: When the working sum is below the selected price, no motor pulses and `credit` becomes the working sum. A motor stays high no longer than the cycle after its vend decision unless a new vend is decided.
- R7: Credit saturates: a sum above 255 cents is held at 255.
- R8: `refund_req` makes `refund_valid` high for one cycle. `refund_amt` then equals the working sum, coins of that cycle included, and `credit` becomes zero.
- R9: When a refund and an affordable vend fall in the same cycle, the refund wins and no motor pulses.
- R10: With `item_sel` equal to 3, no motor ever pulses, whatever the credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coin_quarter | input | 1 | One-cycle pulse for a 25-cent coin |
| coin_dime | input | 1 | One-cycle pulse for a 10-cent coin |
| coin_nickel | input | 1 | One-cycle pulse for a 5-cent coin |
| item_sel | input | 2 | Selected product (0 X, 1 Y, 2 Z, 3 none) |
| refund_req | input | 1 | Request to return all credit |
| motor_x | output | 1 | Vend pulse for the 125-cent product |
| motor_y | output | 1 | Vend pulse for the 30-cent product |
| motor_z | output | 1 | Vend pulse for the 60-cent product |
| refund_valid | output | 1 | Refund amount is valid this cycle |
| refund_amt | output | 8 | Cents returned, valid with `refund_valid` |
| credit | output | 8 | Current credit in cents |

## Verification
Two functions can meet in one cycle here. The first is a vend decision together with a coin arriving. The bench drives a dime in the same cycle that it selects Z, with 50 cents already held, and expects the vend and zero credit left over. The second is a refund request while the held credit covers the selected item. The bench raises `refund_req` with Y selected and 225 cents held, then checks that the refund carries the full sum and that no motor pulses.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int NUM_COINS = 3;
  localparam int NUM_ITEMS = 3;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_X    = 2'd0,
    SEL_Y    = 2'd1,
    SEL_Z    = 2'd2,
    SEL_NONE = 2'd3
  } item_sel_e;
endpackage

// File: rtl/vend_coin_sum.sv
module vend_coin_sum #(
  parameter int SUM_W = 8,
  parameter int NUM   = 3,
  parameter int unsigned VALS [NUM] = '{25, 10, 5}
) (
  input  logic [NUM-1:0]   hit,
  output logic [SUM_W-1:0] total
);
  logic [SUM_W-1:0] term [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_term
    assign term[i] = hit[i] ? SUM_W'(VALS[i]) : '0;
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM; i++) total = total + term[i];
  end
endmodule

// File: rtl/vend_price_sel.sv
module vend_price_sel
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 8,
  parameter int unsigned PRICES [NUM_ITEMS] = '{125, 30, 60}
) (
  input  logic [SEL_W-1:0]    sel,
  output logic [CREDIT_W-1:0] price,
  output logic                item_ok,
  output logic [NUM_ITEMS-1:0] item_hot
);
  for (genvar i = 0; i < NUM_ITEMS; i++) begin : g_hot
    assign item_hot[i] = (sel == SEL_W'(i));
  end

  assign item_ok = |item_hot;

  always_comb begin
    price = '0;
    for (int i = 0; i < NUM_ITEMS; i++)
      if (item_hot[i]) price = CREDIT_W'(PRICES[i]);
  end
endmodule

// File: rtl/vend_credit.sv
module vend_credit
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 8,
  parameter int COIN_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [COIN_W-1:0]    coin_total,
  input  logic [CREDIT_W-1:0]  price,
  input  logic                 item_ok,
  input  logic [NUM_ITEMS-1:0] item_hot,
  input  logic                 refund_req,
  output logic [CREDIT_W-1:0]  credit,
  output logic [NUM_ITEMS-1:0] motor,
  output logic                 refund_valid,
  output logic [CREDIT_W-1:0]  refund_amt
);
  localparam int WIDE_W = CREDIT_W + 2;
  localparam logic [WIDE_W-1:0] CAP = WIDE_W'((1 << CREDIT_W) - 1);

  logic [WIDE_W-1:0]   raw_sum;
  logic [CREDIT_W-1:0] work_sum;
  logic                afford;

  assign raw_sum  = WIDE_W'(credit) + WIDE_W'(coin_total);
  assign work_sum = (raw_sum > CAP) ? CAP[CREDIT_W-1:0] : raw_sum[CREDIT_W-1:0];
  assign afford   = item_ok && (work_sum >= price);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit       <= '0;
      motor        <= '0;
      refund_valid <= 1'b0;
      refund_amt   <= '0;
    end else if (refund_req) begin
      credit       <= '0;
      motor        <= '0;
      refund_valid <= 1'b1;
      refund_amt   <= work_sum;
    end else begin
      refund_valid <= 1'b0;
      refund_amt   <= '0;
      if (afford) begin
        credit <= work_sum - price;
        motor  <= item_hot;
      end else begin
        credit <= work_sum;
        motor  <= '0;
      end
    end
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 8,
  parameter int VAL_Q    = 25,
  parameter int VAL_D    = 10,
  parameter int VAL_N    = 5,
  parameter int PRICE_X  = 125,
  parameter int PRICE_Y  = 30,
  parameter int PRICE_Z  = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coin_quarter,
  input  logic                coin_dime,
  input  logic                coin_nickel,
  input  logic [1:0]          item_sel,
  input  logic                refund_req,
  output logic                motor_x,
  output logic                motor_y,
  output logic                motor_z,
  output logic                refund_valid,
  output logic [CREDIT_W-1:0] refund_amt,
  output logic [CREDIT_W-1:0] credit
);
  localparam int COIN_W = $clog2(VAL_Q + VAL_D + VAL_N + 1);

  logic [COIN_W-1:0]    coin_total;
  logic [CREDIT_W-1:0]  price;
  logic                 item_ok;
  logic [NUM_ITEMS-1:0] item_hot;
  logic [NUM_ITEMS-1:0] motor;

  vend_coin_sum #(
    .SUM_W (COIN_W),
    .NUM   (NUM_COINS),
    .VALS  ('{VAL_Q, VAL_D, VAL_N})
  ) u_coins (
    .hit   ({coin_nickel, coin_dime, coin_quarter}),
    .total (coin_total)
  );

  vend_price_sel #(
    .CREDIT_W (CREDIT_W),
    .PRICES   ('{PRICE_X, PRICE_Y, PRICE_Z})
  ) u_price (
    .sel      (item_sel),
    .price    (price),
    .item_ok  (item_ok),
    .item_hot (item_hot)
  );

  vend_credit #(
    .CREDIT_W (CREDIT_W),
    .COIN_W   (COIN_W)
  ) u_credit (
    .clk          (clk),
    .rst_n        (rst_n),
    .coin_total   (coin_total),
    .price        (price),
    .item_ok      (item_ok),
    .item_hot     (item_hot),
    .refund_req   (refund_req),
    .credit       (credit),
    .motor        (motor),
    .refund_valid (refund_valid),
    .refund_amt   (refund_amt)
  );

  assign motor_x = motor[0];
  assign motor_y = motor[1];
  assign motor_z = motor[2];
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int CREDIT_W = 8,
  parameter int VAL_Q    = 25,
  parameter int VAL_D    = 10,
  parameter int VAL_N    = 5,
  parameter int PRICE_X  = 125,
  parameter int PRICE_Y  = 30,
  parameter int PRICE_Z  = 60
) (
  input logic                clk,
  input logic                rst_n,
  input logic                coin_quarter,
  input logic                coin_dime,
  input logic                coin_nickel,
  input logic [1:0]          item_sel,
  input logic                refund_req,
  input logic                motor_x,
  input logic                motor_y,
  input logic                motor_z,
  input logic                refund_valid,
  input logic [CREDIT_W-1:0] refund_amt,
  input logic [CREDIT_W-1:0] credit
);
  localparam int CAP = (1 << CREDIT_W) - 1;

  int unsigned coins_now;
  int unsigned sum_now;

  assign coins_now = (coin_quarter ? VAL_Q : 0) + (coin_dime ? VAL_D : 0)
                   + (coin_nickel ? VAL_N : 0);
  assign sum_now   = (int'(credit) + coins_now > CAP) ? CAP : int'(credit) + coins_now;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (credit == '0 && !motor_x && !motor_y && !motor_z && !refund_valid));

  p_one_motor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({motor_x, motor_y, motor_z}));

  p_refund_beats_vend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refund_valid |-> !(motor_x || motor_y || motor_z));

  p_refund_amount_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refund_valid && $past(rst_n)) |-> (int'(refund_amt) == $past(sum_now) && credit == '0));

  p_idle_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (item_sel == 2'd3 && !refund_req) |=> !(motor_x || motor_y || motor_z));

  p_deduct_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_x && $past(rst_n)) |-> (int'(credit) + PRICE_X == $past(sum_now)));

  p_deduct_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_y && $past(rst_n)) |-> (int'(credit) + PRICE_Y == $past(sum_now)));

  p_deduct_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_z && $past(rst_n)) |-> (int'(credit) + PRICE_Z == $past(sum_now)));

  p_hold_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !refund_valid && !motor_x && !motor_y && !motor_z)
      |-> (int'(credit) == $past(sum_now)));
endmodule

bind vend_ctrl vend_ctrl_chk #(
  .CREDIT_W (CREDIT_W),
  .VAL_Q    (VAL_Q),
  .VAL_D    (VAL_D),
  .VAL_N    (VAL_N),
  .PRICE_X  (PRICE_X),
  .PRICE_Y  (PRICE_Y),
  .PRICE_Z  (PRICE_Z)
) u_chk (.*);

// File: tb/vend_ctrl_test.sv
module vend_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coin_quarter = 1'b0;
  logic       coin_dime = 1'b0;
  logic       coin_nickel = 1'b0;
  logic [1:0] item_sel = 2'd3;
  logic       refund_req = 1'b0;
  logic       motor_x, motor_y, motor_z, refund_valid;
  logic [7:0] refund_amt, credit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  vend_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .coin_quarter (coin_quarter),
    .coin_dime    (coin_dime),
    .coin_nickel  (coin_nickel),
    .item_sel     (item_sel),
    .refund_req   (refund_req),
    .motor_x      (motor_x),
    .motor_y      (motor_y),
    .motor_z      (motor_z),
    .refund_valid (refund_valid),
    .refund_amt   (refund_amt),
    .credit       (credit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus; returns at the next falling edge with the
  // results of the rising edge in between visible on the outputs.
  task automatic cyc(input bit q, input bit d, input bit n, input logic [1:0] s, input bit r);
    coin_quarter = q;
    coin_dime    = d;
    coin_nickel  = n;
    item_sel     = s;
    refund_req   = r;
    @(negedge clk);
    coin_quarter = 1'b0;
    coin_dime    = 1'b0;
    coin_nickel  = 1'b0;
    refund_req   = 1'b0;
  endtask

  task automatic expect_out(input string req, input int cr, input bit x, input bit y,
                            input bit z, input bit rv, input int ra);
    chk(int'(credit) == cr, {req, " credit"}, credit, cr);
    chk({motor_x, motor_y, motor_z} == {x, y, z}, {req, " motors xyz"},
        {motor_x, motor_y, motor_z}, {x, y, z});
    chk(refund_valid == rv, {req, " refund_valid"}, refund_valid, rv);
    if (rv) chk(int'(refund_amt) == ra, {req, " refund_amt"}, refund_amt, ra);
  endtask

  task automatic t_reset;
    expect_out("R1 reset", 0, 0, 0, 0, 0, 0);
    chk(refund_amt == 8'd0, "R1 refund_amt", refund_amt, 0);
  endtask

  task automatic t_coin_values;
    cyc(0, 0, 1, 2'd3, 0); expect_out("R2 nickel", 5, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 2'd3, 0); expect_out("R2 dime", 15, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 2'd3, 0); expect_out("R2 quarter R10 idle", 40, 0, 0, 0, 0, 0);
  endtask

  task automatic t_refund_and_multi;
    cyc(0, 0, 0, 2'd3, 1); expect_out("R8 refund", 0, 0, 0, 0, 1, 40);
    cyc(0, 0, 0, 2'd3, 0); chk(!refund_valid, "R8 refund one cycle", refund_valid, 0);
    cyc(1, 1, 1, 2'd3, 0); expect_out("R2 three coins at once", 40, 0, 0, 0, 0, 0);
  endtask

  task automatic t_vend_y;
    cyc(0, 0, 0, 2'd1, 0); expect_out("R4 R3 vend Y", 10, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 2'd1, 0); expect_out("R6 pulse ends, short credit", 10, 0, 0, 0, 0, 0);
  endtask

  task automatic t_vend_x;
    cyc(1, 0, 0, 2'd3, 1); expect_out("R8 refund with coin", 0, 0, 0, 0, 1, 35);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 2'd3, 0);
    expect_out("R2 five quarters", 125, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 2'd0, 0); expect_out("R4 R3 vend X exact", 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_vend_z_with_coin;
    cyc(1, 0, 0, 2'd3, 0);
    cyc(1, 0, 0, 2'd3, 0); expect_out("R2 fifty", 50, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 2'd2, 0); expect_out("R4 R5 vend Z with coin", 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_below_price;
    cyc(1, 0, 0, 2'd0, 0); expect_out("R6 below price X", 25, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 2'd3, 1); expect_out("R8 refund 25", 0, 0, 0, 0, 1, 25);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 2'd3, 0);
    expect_out("R7 250", 250, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 2'd3, 0); expect_out("R7 reaches 255", 255, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 2'd3, 0); expect_out("R7 held at 255", 255, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 2'd1, 0); expect_out("R4 vend Y from cap", 225, 0, 1, 0, 0, 0);
  endtask

  task automatic t_refund_vs_vend;
    cyc(0, 0, 0, 2'd1, 1); expect_out("R9 refund wins", 0, 0, 0, 0, 1, 225);
    cyc(0, 0, 0, 2'd3, 0); expect_out("R9 after refund", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_coin_values();
    t_refund_and_multi();
    t_vend_y();
    t_vend_x();
    t_vend_z_with_coin();
    t_below_price();
    t_saturate();
    t_refund_vs_vend();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule